// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block receives a stereo audio stream on a three-wire serial link: a bit clock, a left/right word clock and one data line. It runs as a slave. The bit clock does not enter as a clock. It arrives as a one-cycle enable pulse in the system clock domain, and each pulse marks one bit-clock rising edge. One sample period holds 64 bit clocks, which gives 32 bit slots to each channel. At every enabled edge the block samples the word clock and the data line.

Four framing conventions are selected through configuration:

- I2S-style, with a one-bit delay.
- Left-justified.
- Right-justified.
- A DSP-style frame marked by a single-bit pulse.

The word length is also selected through configuration, and can be 16, 20 or 24 bits. One shift register and one bit-position counter serve every combination. Only the slot at which a word is captured changes between them. Each completed word is sign-extended to 24 bits and presented on its channel's output, together with a one-cycle valid pulse.

The bit-position counter is aligned by the word clock. A word-clock edge that arrives where the counter does not expect one realigns the counter to that edge and sets a sticky error flag. Only reset clears the flag.

Top module: `audio_rx_multi`

## Requirements
- R1: After reset, `left_data` and `right_data` are zero, and `left_valid`, `right_valid` and `frame_err` are low.
- R2: With `fmt`=0 (I2S-style), word clock low selects the left channel, and the MSB is sampled one bit clock after the word-clock transition.
- R3: With `fmt`=1 (left-justified), word clock high selects the left channel, and the MSB is sampled in the same bit clock as the word-clock transition.
- R4: With `fmt`=2 (right-justified), word clock high selects the left channel, and the LSB is sampled in slot 31, the last slot before the next transition. Slot 0 is the transition bit.
- R5: With `fmt`=3 (DSP-style), a rising word clock that is high for one bit marks the frame start. The left MSB is sampled in that same bit. The right word follows directly after the left LSB, MSB first.
- R6: `wlen`=0 selects 16-bit words, 1 selects 20-bit words, and 2 or 3 select 24-bit words. The received word is sign-extended to 24 bits. Data bits outside the word's slots have no effect.
- R7: Each received word produces exactly one system-clock cycle of its channel's valid signal. That cycle is the one after the enable that carried the word's last bit. `left_valid` and `right_valid` are never high together.
- R8: A word-clock edge that arrives at an unexpected bit count has two effects. It sets `frame_err`, which stays set until reset. It also realigns the bit counter, so the following words are received relative to that edge.
- R9: No word is output before the first word-clock edge after reset.
- R10: `wclk` and `sdata` are sampled only in cycles where `bclk_en` is high. Their values in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle pulse per bit-clock rising edge |
| wclk | input | 1 | Left/right word clock, or frame pulse in DSP mode |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing: 0 I2S-style, 1 left-justified, 2 right-justified, 3 DSP |
| wlen | input | 2 | Word length: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| left_data | output | 24 | Last left word, sign-extended |
| left_valid | output | 1 | One-cycle pulse when `left_data` updates |
| right_data | output | 24 | Last right word, sign-extended |
| right_valid | output | 1 | One-cycle pulse when `right_data` updates |
| frame_err | output | 1 | Sticky flag for an unexpected word-clock edge |

## Verification
The bench fills every data slot outside the word with ones. A receiver that captures at the wrong slot or with the wrong alignment therefore returns shifted values or values padded with ones. The bench uses negative words in 16-bit and 20-bit mode to expose missing sign extension, and it runs the right-justified mode, where an off-by-one at the word end drops the LSB. Between enables it drives garbage on both the data and word-clock lines, so a receiver that samples outside `bclk_en` corrupts its words or loses sync. The bench also cuts one left word short with an early edge. A receiver without resynchronisation would miss the following right word, and one whose flag is not sticky would clear it on the next good frame.

// File: rtl/audio_rx_multi.sv
module audio_rx_multi #(
  parameter int DW    = 24,
  parameter int SLOTS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_en,
  input  logic          wclk,
  input  logic          sdata,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wlen,
  output logic [DW-1:0] left_data,
  output logic          left_valid,
  output logic [DW-1:0] right_data,
  output logic          right_valid,
  output logic          frame_err
);

  localparam int CW = $clog2(2*SLOTS);
  localparam int SW = CW - 1;
  localparam logic [1:0] F_I2S = 2'd0, F_LJ = 2'd1, F_RJ = 2'd2, F_DSP = 2'd3;
  localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS-1);
  localparam logic [CW-1:0] HALF      = CW'(SLOTS);
  localparam logic [CW-1:0] FULL_W    = CW'(DW);

  logic          wc_q, seen, locked;
  logic [CW-1:0] pos_q, pos_inc, pos_n, slot, wbits, amt;
  logic [DW-1:0] sh, sh_n, up;
  logic [DW-1:0] ext;
  logic          edge_det, left_lvl, bad_edge, lock_n, hi, cap_l, cap_r;

  always_comb begin
    case (wlen)
      2'd0:    wbits = CW'(16);
      2'd1:    wbits = CW'(20);
      default: wbits = CW'(24);
    endcase
  end

  assign edge_det = seen && ((fmt == F_DSP) ? (wclk && !wc_q) : (wclk != wc_q));
  assign left_lvl = (fmt == F_I2S) ? !wclk : wclk;
  assign pos_inc  = pos_q + 1'b1;
  assign pos_n    = !edge_det ? pos_inc :
                    ((fmt == F_DSP || left_lvl) ? '0 : HALF);
  assign bad_edge = edge_det && locked && (pos_inc != pos_n);
  assign lock_n   = locked || edge_det;
  assign sh_n     = {sh[DW-2:0], sdata};
  assign slot     = {1'b0, pos_n[SW-1:0]};
  assign hi       = pos_n[SW];

  assign amt = FULL_W - wbits;
  assign up  = sh_n << amt;
  assign ext = DW'($signed(up) >>> amt);

  always_comb begin
    cap_l = 1'b0;
    cap_r = 1'b0;
    case (fmt)
      F_I2S: begin
        cap_l = (slot == wbits) && !hi;
        cap_r = (slot == wbits) &&  hi;
      end
      F_LJ: begin
        cap_l = (slot == wbits - 1'b1) && !hi;
        cap_r = (slot == wbits - 1'b1) &&  hi;
      end
      F_RJ: begin
        cap_l = (slot == LAST_SLOT) && !hi;
        cap_r = (slot == LAST_SLOT) &&  hi;
      end
      default: begin
        cap_l = (pos_n == wbits - 1'b1);
        cap_r = (pos_n == (wbits << 1) - 1'b1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc_q        <= 1'b0;
      seen        <= 1'b0;
      locked      <= 1'b0;
      pos_q       <= '0;
      sh          <= '0;
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      if (bclk_en) begin
        wc_q   <= wclk;
        seen   <= 1'b1;
        sh     <= sh_n;
        pos_q  <= pos_n;
        locked <= lock_n;
        if (bad_edge) frame_err <= 1'b1;
        if (lock_n && cap_l) begin
          left_data  <= ext;
          left_valid <= 1'b1;
        end
        if (lock_n && cap_r) begin
          right_data  <= ext;
          right_valid <= 1'b1;
        end
      end
    end
  end

  // R7
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |=> !(left_valid || right_valid));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R10
  valid_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> $past(bclk_en));

  // R9
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> locked);

  // R6
  sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && wlen == 2'd0) |-> (&left_data[DW-1:15] || ~|left_data[DW-1:15]));

endmodule

// File: tb/test_audio_rx_multi.sv
module test_audio_rx_multi;
  logic clk = 1'b0, rst_n = 1'b0, bclk_en = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd0;
  logic [23:0] left_data, right_data;
  logic left_valid, right_valid, frame_err;

  int n_chk = 0, n_bad = 0, nl = 0, nr = 0, n_both = 0;
  logic [23:0] got_l = '0, got_r = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_rx_multi i_audio_rx_multi (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .wclk(wclk), .sdata(sdata),
    .fmt(fmt), .wlen(wlen), .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid), .frame_err(frame_err));

  always @(negedge clk) begin
    if (left_valid)  begin nl++; got_l = left_data;  end
    if (right_valid) begin nr++; got_r = right_data; end
    if (left_valid && right_valid) n_both++;
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wl(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int w);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  // returns {wclk, data} for frame bit b; unused slots carry ones
  function automatic logic [1:0] fbit(input logic [1:0] f, input int w, input int b,
                                      input logic [23:0] L, input logic [23:0] R);
    logic wc, d;
    int s;
    logic [23:0] v;
    d = 1'b1;
    if (f == 2'd3) begin
      wc = (b == 0);
      if (b < w) d = L[w-1-b];
      else if (b < 2*w) d = R[2*w-1-b];
    end else begin
      s = b % 32;
      v = (b < 32) ? L : R;
      wc = (f == 2'd0) ? (b >= 32) : (b < 32);
      case (f)
        2'd0: if (s >= 1 && s <= w) d = v[w-s];
        2'd1: if (s < w) d = v[w-1-s];
        default: if (s >= 32-w) d = v[31-s];
      endcase
    end
    return {wc, d};
  endfunction

  task automatic send_bit(input logic wc, input logic d);
    @(negedge clk); wclk = wc; sdata = d; bclk_en = 1'b1;
    @(negedge clk); bclk_en = 1'b0; sdata = ~d; wclk = ~wc;  // R10 garbage between enables
    @(negedge clk); sdata = d;
    @(negedge clk); wclk = wc;
  endtask

  task automatic send_range(input int b0, input int b1, input logic [23:0] L, input logic [23:0] R);
    logic [1:0] p;
    for (int b = b0; b <= b1; b++) begin
      p = fbit(fmt, wl(wlen), b, L, R);
      send_bit(p[1], p[0]);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
    @(negedge clk); rst_n = 1'b0; bclk_en = 1'b0; fmt = f; wlen = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nl = 0; nr = 0;
  endtask

  task automatic pre_bit();
    send_bit((fmt == 2'd0) ? 1'b1 : 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_data == 0 && right_data == 0, "R1 data zero", left_data | right_data, 24'h0);
    chk(!left_valid && !right_valid && !frame_err, "R1 flags low",
        {21'h0, left_valid, right_valid, frame_err}, 24'h0);
  endtask

  task automatic t_format(input logic [1:0] f, input logic [1:0] w, input string req,
                          input logic [23:0] L1, input logic [23:0] R1,
                          input logic [23:0] L2, input logic [23:0] R2);
    int ww;
    ww = wl(w);
    do_reset(f, w);
    pre_bit();
    send_range(0, 63, L1, R1);
    chk(nl == 1 && nr == 1, {req, " R7 one valid per word"}, 24'(nl*16 + nr), 24'h11);
    chk(got_l == sx(L1, ww), {req, " left word 1"}, got_l, sx(L1, ww));
    chk(got_r == sx(R1, ww), {req, " right word 1"}, got_r, sx(R1, ww));
    send_range(0, 63, L2, R2);
    chk(got_l == sx(L2, ww), {req, " R6 left word 2"}, got_l, sx(L2, ww));
    chk(got_r == sx(R2, ww), {req, " R6 right word 2"}, got_r, sx(R2, ww));
    chk(!frame_err && n_both == 0, {req, " R8/R7 no error, no overlap"},
        24'(frame_err), 24'h0);
  endtask

  task automatic t_nolock();
    do_reset(2'd1, 2'd2);
    for (int i = 0; i < 70; i++) send_bit(1'b1, i[0]);
    chk(nl == 0 && nr == 0, "R9 no output before edge", 24'(nl + nr), 24'h0);
    chk(!frame_err, "R9 no error before lock", 24'(frame_err), 24'h0);
  endtask

  task automatic t_resync();
    do_reset(2'd1, 2'd2);
    pre_bit();
    send_range(0, 63, 24'h123456, 24'h654321);
    chk(!frame_err, "R8 clean before glitch", 24'(frame_err), 24'h0);
    send_range(0, 9, 24'hAAAAAA, 24'h0);
    send_range(32, 63, 24'h0, 24'hC0FFEE);
    chk(frame_err, "R8 error raised", 24'(frame_err), 24'h1);
    chk(nl == 1 && nr == 2, "R8 short left dropped, right taken", 24'(nl*16 + nr), 24'h12);
    chk(got_r == 24'hC0FFEE, "R8 right after resync", got_r, 24'hC0FFEE);
    send_range(0, 63, 24'h0BEEF0, 24'hF00D11);
    chk(got_l == 24'h0BEEF0 && got_r == 24'hF00D11, "R8 following frame", got_l, 24'h0BEEF0);
    chk(frame_err, "R8 error sticky", 24'(frame_err), 24'h1);
  endtask

  initial begin
    t_reset();
    t_format(2'd0, 2'd2, "R2 I2S 24b", 24'h812345, 24'h7ABCDE, 24'h000001, 24'hFFFFFE);
    t_format(2'd0, 2'd1, "R2 I2S 20b", 24'h080001, 24'h07FFFF, 24'h0ABCDE, 24'h012345);
    t_format(2'd1, 2'd0, "R3 LJ 16b", 24'h008000, 24'h001234, 24'h00FFFF, 24'h007FFF);
    t_format(2'd1, 2'd3, "R3 LJ 24b", 24'hA5A5A5, 24'h5A5A5A, 24'h800000, 24'h7FFFFF);
    t_format(2'd2, 2'd1, "R4 RJ 20b", 24'h0F0F0F, 24'h080000, 24'h000003, 24'h0FFFFF);
    t_format(2'd2, 2'd0, "R4 RJ 16b", 24'h00C001, 24'h000001, 24'h0089AB, 24'h004321);
    t_format(2'd3, 2'd2, "R5 DSP 24b", 24'hDEAD01, 24'h13579B, 24'h2468AC, 24'hFEDCBA);
    t_format(2'd3, 2'd0, "R5 DSP 16b", 24'h00F001, 24'h000F10, 24'h008888, 24'h001111);
    t_nolock();
    t_resync();
    chk(n_both == 0, "R7 left and right never together", 24'(n_both), 24'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule